// File: doc/BRIEF.md
# Successive Approximation Conversion Controller

This block is the digital sequencer of a successive approximation analog-to-digital converter. It runs a binary search over an N-bit code. The code drives an external DAC, and a single external comparator reports whether the DAC output lies below the analog input. The block decides one bit per clock, starting with the most significant bit. Each decided bit is kept or cleared according to the comparator. A conversion therefore always takes exactly N comparisons, whatever the input level.

A pulse on the start input while the block is idle launches a conversion. Busy stays high for the N decision cycles. A one-cycle done pulse then marks the arrival of a new registered result. That result stays on the output until the next conversion completes. The search is built from two registers: a one-hot pointer that marks the bit under trial, and the accumulated code of the bits already decided. The DAC receives the two ORed together.

Top module: `sar_adc_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after its release, busy, done, the trial code and the result are all zero.
- R2: A start sampled at a clock edge while idle makes busy 1 after that edge, with a trial code that has only bit N-1 set.
- R3: At each clock edge while busy, the comparator input is sampled. A value of 1 (DAC below input) keeps the bit under trial as 1, and a value of 0 clears it. The next trial code then holds all decided bits plus the next lower bit set to 1.
- R4: Busy stays high for exactly N cycles, one per comparison. In the cycle after the decision on bit 0, busy is 0 and done is 1.
- R5: When done is 1, the result equals the code formed by all N decisions. With the comparator modelled as "trial code not above a target", the result is exactly that target.
- R6: Done is high for a single cycle. The result does not change until the next done.
- R7: A start while busy is ignored: the conversion in progress keeps its N-cycle length and its result.
- R8: A start in the cycle where done is 1 is accepted. The next cycle begins a new conversion with trial code bit N-1 only, while the previous result is still shown.
- R9: The trial code is zero whenever busy is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Request a conversion (ignored while busy) |
| cmp_below_i | input | 1 | Comparator: 1 when the DAC output is below the analog input |
| trial_code_o | output | N | Code applied to the DAC during the search |
| result_o | output | N | Last completed conversion result |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle pulse when a new result is available |

## Verification
Completion and launch can coincide: the done pulse for one conversion can share its cycle with an accepted start for the next. The bench provokes this by holding start high during the done cycle of a sweep conversion. In the following cycle it expects busy high, a trial code of the top bit alone, and the old result unchanged. It then checks that the chained conversion still resolves its own target in N steps. A second overlap, a start during the final decision cycle, is judged by requiring that the run ends on schedule and no extra conversion follows.

// File: rtl/sar_pkg.sv
// Package: shared types for the successive approximation controller.
// Assumes: nothing beyond standard SystemVerilog.
package sar_pkg;
    // Sequencer phase: waiting for a start, or resolving bits.
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_CONV = 1'b1
    } sar_phase_e;
endpackage

// File: rtl/sar_bit_pointer.sv
// Module: one-hot pointer to the bit under trial.
// Loads the top bit on launch and walks one place toward bit 0 per decision.
// It becomes all zero after bit 0 is decided.
// Assumes: load_i and step_i are never high together.
module sar_bit_pointer #(
    parameter int N = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         step_i,
    output logic [N-1:0] ptr_o,
    output logic         last_o
);
    localparam logic [N-1:0] TOP_BIT = {1'b1, {(N-1){1'b0}}};

    logic [N-1:0] ptr_q;

    // Pointer register: load top bit, shift right on every decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (load_i) begin
            ptr_q <= TOP_BIT;
        end else if (step_i) begin
            ptr_q <= ptr_q >> 1;
        end
    end

    assign ptr_o  = ptr_q;
    assign last_o = ptr_q[0];
endmodule

// File: rtl/sar_code_accum.sv
// Module: accumulated code of decided bits.
// Clears on launch. On each decision it sets the pointed bit when the comparator says keep.
// Assumes: ptr_i is one-hot or zero.
module sar_code_accum #(
    parameter int N = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear_i,
    input  logic         step_i,
    input  logic         keep_i,
    input  logic [N-1:0] ptr_i,
    output logic [N-1:0] acc_o
);
    logic [N-1:0] acc_q;

    for (genvar b = 0; b < N; b++) begin : g_bit
        // Per-bit accumulator: cleared on launch, set once when kept.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                acc_q[b] <= 1'b0;
            end else if (clear_i) begin
                acc_q[b] <= 1'b0;
            end else if (step_i && ptr_i[b] && keep_i) begin
                acc_q[b] <= 1'b1;
            end
        end
    end

    assign acc_o = acc_q;
endmodule

// File: rtl/sar_seq_ctrl.sv
// Module: conversion sequencer.
// Accepts a start only when idle and runs one decision per cycle until the pointer reaches bit 0.
// On finishing it registers the result and pulses done.
// Assumes: last_i is high exactly in the cycle bit 0 is under trial.
module sar_seq_ctrl
    import sar_pkg::*;
#(
    parameter int N = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic         last_i,
    input  logic         cmp_i,
    input  logic [N-1:0] acc_i,
    input  logic [N-1:0] ptr_i,
    output logic         launch_o,
    output logic         step_o,
    output logic         busy_o,
    output logic         done_o,
    output logic [N-1:0] result_o
);
    sar_phase_e   phase_q;
    logic         done_q;
    logic [N-1:0] result_q;
    logic         finish;

    assign launch_o = start_i && (phase_q == PH_IDLE);
    assign step_o   = (phase_q == PH_CONV);
    assign finish   = step_o && last_i;

    // Phase register: idle -> conv on launch, conv -> idle after bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
        end else if (launch_o) begin
            phase_q <= PH_CONV;
        end else if (finish) begin
            phase_q <= PH_IDLE;
        end
    end

    // Done pulse: high for the one cycle after the final decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else begin
            done_q <= finish;
        end
    end

    // Result register: captures the full code including the final bit decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
        end else if (finish) begin
            result_q <= acc_i | (cmp_i ? ptr_i : '0);
        end
    end

    assign busy_o   = step_o;
    assign done_o   = done_q;
    assign result_o = result_q;
endmodule

// File: rtl/sar_adc_ctrl.sv
// Module: top of the successive approximation controller.
// Binary search over an N-bit code, one bit per clock, MSB first.
// Trial code = decided bits OR pointer, forced to zero when idle.
// Assumes: the comparator input settles within one clock of a new trial code.
module sar_adc_ctrl #(
    parameter int N = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic         cmp_below_i,
    output logic [N-1:0] trial_code_o,
    output logic [N-1:0] result_o,
    output logic         busy_o,
    output logic         done_o
);
    logic         launch;
    logic         step;
    logic         last;
    logic [N-1:0] ptr;
    logic [N-1:0] acc;

    sar_seq_ctrl #(.N(N)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .last_i   (last),
        .cmp_i    (cmp_below_i),
        .acc_i    (acc),
        .ptr_i    (ptr),
        .launch_o (launch),
        .step_o   (step),
        .busy_o   (busy_o),
        .done_o   (done_o),
        .result_o (result_o)
    );

    sar_bit_pointer #(.N(N)) u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (launch),
        .step_i (step),
        .ptr_o  (ptr),
        .last_o (last)
    );

    sar_code_accum #(.N(N)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (launch),
        .step_i  (step),
        .keep_i  (cmp_below_i),
        .ptr_i   (ptr),
        .acc_o   (acc)
    );

    // DAC drive: combine decided bits with the bit under trial while converting.
    always_comb begin
        trial_code_o = busy_o ? (acc | ptr) : '0;
    end
endmodule

// File: rtl/sar_adc_ctrl_chk.sv
// Module: protocol checker for sar_adc_ctrl, attached by bind.
// Uses a local busy-cycle counter in place of long $past windows.
// Assumes: reset is asserted at time zero.
module sar_adc_ctrl_chk #(
    parameter int N = 10
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start_i,
    input logic [N-1:0] trial_code_o,
    input logic [N-1:0] result_o,
    input logic         busy_o,
    input logic         done_o
);
    localparam int CW = $clog2(N + 1);
    localparam logic [N-1:0] TOP_BIT = {1'b1, {(N-1){1'b0}}};

    logic [CW-1:0] busy_cnt;

    // Busy-cycle counter: counts cycles of the current conversion.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy_o) begin
            busy_cnt <= '0;
        end else begin
            busy_cnt <= busy_cnt + 1'b1;
        end
    end

    // R2
    start_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (busy_o && trial_code_o == TOP_BIT));

    // R4
    step_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && busy_cnt == CW'(N-1)) |=> (!busy_o && done_o));

    // R4
    step_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && busy_cnt < CW'(N-1)) |=> busy_o);

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R6
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(result_o));

    // R9
    idle_trial_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (trial_code_o == '0));

    // R4
    done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);
endmodule

bind sar_adc_ctrl sar_adc_ctrl_chk #(.N(N)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .trial_code_o (trial_code_o),
    .result_o     (result_o),
    .busy_o       (busy_o),
    .done_o       (done_o)
);

// File: tb/sar_adc_ctrl_test.sv
// Bench: exhaustive sweep of all targets for a 5-bit configuration.
// The comparator reports "DAC below input" when the trial code is not above the target.
module sar_adc_ctrl_test;
    localparam int N = 5;
    localparam int FULL = (1 << N) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic         cmp_below_i;
    logic [N-1:0] trial_code_o;
    logic [N-1:0] result_o;
    logic         busy_o;
    logic         done_o;
    int           tgt = 0;
    int           checks = 0;
    int           fails = 0;
    bit           finished = 1'b0;

    always #2.5 clk = ~clk;

    assign cmp_below_i = (int'(trial_code_o) <= tgt);

    sar_adc_ctrl #(.N(N)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .cmp_below_i  (cmp_below_i),
        .trial_code_o (trial_code_o),
        .result_o     (result_o),
        .busy_o       (busy_o),
        .done_o       (done_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One conversion. pre: start already accepted at the previous edge.
    // poke_at: step where a stray start is raised (-1 none). chain: raise start in done cycle.
    task automatic convert(input int t, input bit pre, input int prev,
                           input int poke_at, input bit chain);
        tgt = t;
        if (!pre) begin
            @(negedge clk) start_i = 1'b1;
            @(negedge clk) start_i = 1'b0;
        end else begin
            // R8: old result still shown while the new search starts
            chk(result_o == N'(prev), "R8", int'(result_o), prev);
        end
        for (int k = 0; k < N; k++) begin
            int pos;
            int above;
            int exp;
            pos   = N - 1 - k;
            above = FULL & ~((1 << (pos + 1)) - 1);
            exp   = (t & above) | (1 << pos);
            chk(busy_o === 1'b1, (k == 0) ? "R2" : "R4", int'(busy_o), 1);
            chk(trial_code_o == N'(exp), (k == 0) ? "R2" : "R3", int'(trial_code_o), exp);
            start_i = (k == poke_at);
            @(negedge clk);
        end
        start_i = 1'b0;
        chk(done_o === 1'b1 && busy_o === 1'b0, "R4", {int'(busy_o), int'(done_o)}, 1);
        chk(result_o == N'(t), "R5", int'(result_o), t);
        chk(trial_code_o == '0, "R9", int'(trial_code_o), 0);
        if (poke_at >= 0) begin
            // R7: the stray start must not have extended or restarted the run
            chk(result_o == N'(t), "R7", int'(result_o), t);
        end
        if (chain) begin
            start_i = 1'b1;
            @(negedge clk) start_i = 1'b0;
        end else begin
            @(negedge clk);
            chk(done_o === 1'b0, "R6", int'(done_o), 0);
            chk(result_o == N'(t), "R6", int'(result_o), t);
            chk(busy_o === 1'b0, "R7", int'(busy_o), 0);
        end
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(busy_o === 1'b0 && done_o === 1'b0, "R1", int'(busy_o), 0);
        chk(trial_code_o == '0 && result_o == '0, "R1", int'(result_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy_o === 1'b0 && trial_code_o == '0 && result_o == '0, "R1",
            int'(trial_code_o), 0);
        // Exhaustive sweep of every code, some with stray starts, some chained.
        for (int t = 0; t <= FULL; t++) begin
            convert(t, 1'b0, 0, (t % 4 == 1) ? 2 : ((t % 4 == 3) ? N - 1 : -1), 1'b0);
        end
        // R8: back-to-back chaining across a sweep of targets
        convert(FULL, 1'b0, 0, -1, 1'b1);
        for (int t = 0; t < FULL; t += 3) begin
            convert(t, 1'b1, (t == 0) ? FULL : t - 3, -1, (t + 3 < FULL));
        end
        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule